// File: doc/BRIEF.md
# Synchronizable Multi-Channel Clock Divider

A bank of programmable clock dividers that share one fast input clock. Each channel divides the input by a programmable ratio with a programmable high time and low time, and its divided clock drives both outputs of its output pair. Software-visible registers, the source clock and the output drivers sit outside this block. The block sees only the per-channel configuration fields as plain inputs.

A shared active-low `sync_n` input aligns the channels. While it is low, every participating channel holds its output at a chosen static level. When it goes high, all participating channels restart on the same input clock edge after a fixed latency. Each channel first waits out its own phase offset, so the channels come back with defined relative phases. A channel with its exclude bit set ignores `sync_n` and keeps running. High count, low count, phase and start level are shadowed, so changing them never disturbs a running channel. New values take effect at the next sync. Reset acts as a sync for every channel, excluded or not.

Top module: `clkdiv_sync_bank`

## Requirements
- R1: While `rst_n` is low, every output is 0. The first release after reset starts every channel as a participant, including channels whose `cfg_nosync` bit is set.
- R2: Once a low `sync_n` has passed the 3-flop capture chain, each participating channel (`cfg_nosync` = 0) holds its output at `cfg_start_high`, and that level is stable for as long as the sync lasts.
- R3: Both outputs of a pair, `clk_out_a[i]` and `clk_out_b[i]`, carry the same level on every cycle.
- R4: A running channel has period (high_count+1)+(low_count+1) input cycles. It stays high for high_count+1 cycles and low for low_count+1 cycles.
- R5: Let E1 be the first rising edge that samples `sync_n` high. A participating channel's first level change then falls on edge E1 + 3 + RELEASE_LAT + phase + c. Here c is the high count when start-high is 1 and the low count when it is 0. With the defaults, phase 0 and c = 1, this is 14 edges after E1.
- R6: The phase offset (0 to 15) delays a channel's first transition, and every edge after it, by exactly that many input cycles relative to a channel with offset 0.
- R7: A channel whose `cfg_nosync` bit is 1 during a sync keeps its waveform, period and phase exactly as if no sync had occurred.
- R8: Changes to high count, low count, phase or start-high while a channel runs have no effect on its output until that channel's next sync release.
- R9: With start-high = 1, a channel holds high during sync and spends high_count+1 cycles high after the offset before its first falling edge. With start-high = 0 the first edge is a rising edge after low_count+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast divider input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Asynchronous active-low sync request |
| cfg_high | input | NUM_CH*CNT_W | Per-channel high count, channel i at bits [i*CNT_W +: CNT_W] |
| cfg_low | input | NUM_CH*CNT_W | Per-channel low count, same packing |
| cfg_phase | input | NUM_CH*PH_W | Per-channel phase offset in input cycles |
| cfg_start_high | input | NUM_CH | Per-channel static level during sync and first half after release |
| cfg_nosync | input | NUM_CH | Per-channel exclude bit, read directly (not shadowed) |
| clk_out_a | output | NUM_CH | First output of each pair |
| clk_out_b | output | NUM_CH | Second output of each pair |

## Verification
The hardest situation to reach is an excluded channel crossing a sync while its own configuration has been rewritten. Its waveform must continue unchanged, while its neighbours freeze, reload and restart at different phases. The bench steps through many rounds. In each round it rewrites every channel's configuration mid-run, excludes one rotating channel on every third round, and drives a full sync. It keeps, per channel, an arithmetic model anchored at the edge of its last release, so an excluded channel is judged against a waveform that started many rounds earlier. Rounds with all-maximum and all-zero counts hit the extreme ratios and offsets.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } level_e;

  // cycles - 1 spent in the half whose level is lvl_high
  function automatic int unsigned half_count(bit lvl_high, int unsigned hi,
                                             int unsigned lo);
    return lvl_high ? hi : lo;
  endfunction

  // countdown value loaded at release: offset plus the first half
  function automatic int unsigned preset_count(int unsigned ph, bit st,
                                               int unsigned hi, int unsigned lo);
    return ph + half_count(st, hi, lo);
  endfunction

  function automatic int unsigned div_ratio(int unsigned hi, int unsigned lo);
    return hi + lo + 2;
  endfunction

endpackage

// File: rtl/clkdiv_sync_ctrl.sv
module clkdiv_sync_ctrl #(
  parameter int RELEASE_LAT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic sync_frozen,
  output logic release_p,
  output logic run_start
);
  localparam int LAT_W = $clog2(RELEASE_LAT + 1);

  logic [2:0]       cap_q;
  logic             busy_q;
  logic [LAT_W-1:0] lat_q;
  logic             frozen_d;

  // two synchronizer stages plus one stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= {cap_q[1:0], sync_n};
  end

  assign release_p = cap_q[1] & ~cap_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
    end else if (!cap_q[1]) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
    end else if (release_p) begin
      busy_q <= 1'b1;
      lat_q  <= '0;
    end else if (busy_q) begin
      if (lat_q == LAT_W'(RELEASE_LAT - 1)) busy_q <= 1'b0;
      else                                  lat_q  <= lat_q + 1'b1;
    end
  end

  assign sync_frozen = ~cap_q[2] | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frozen_d <= 1'b1;
    else        frozen_d <= sync_frozen;
  end

  assign run_start = frozen_d & ~sync_frozen;

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int PH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frozen,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [PH_W-1:0]  cfg_phase,
  input  logic             cfg_start,
  output logic             level,
  output logic             wrap
);
  localparam int ACC_W = ((CNT_W > PH_W) ? CNT_W : PH_W) + 1;

  level_e           lvl_q;
  logic [ACC_W-1:0] cnt_q;
  logic [CNT_W-1:0] hi_sh;
  logic [CNT_W-1:0] lo_sh;

  assign wrap  = ~frozen & (cnt_q == '0);
  assign level = (lvl_q == LVL_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_LOW;
      cnt_q <= '0;
      hi_sh <= '0;
      lo_sh <= '0;
    end else if (frozen) begin
      lvl_q <= cfg_start ? LVL_HIGH : LVL_LOW;
      cnt_q <= ACC_W'(preset_count(32'(cfg_phase), cfg_start,
                                   32'(cfg_high), 32'(cfg_low)));
      hi_sh <= cfg_high;
      lo_sh <= cfg_low;
    end else if (wrap) begin
      lvl_q <= (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
      cnt_q <= ACC_W'(half_count(lvl_q == LVL_LOW, 32'(hi_sh), 32'(lo_sh)));
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/clkdiv_sync_bank.sv
module clkdiv_sync_bank #(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 4,
  parameter int PH_W        = 4,
  parameter int RELEASE_LAT = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_n,
  input  logic [NUM_CH*CNT_W-1:0] cfg_high,
  input  logic [NUM_CH*CNT_W-1:0] cfg_low,
  input  logic [NUM_CH*PH_W-1:0]  cfg_phase,
  input  logic [NUM_CH-1:0]       cfg_start_high,
  input  logic [NUM_CH-1:0]       cfg_nosync,
  output logic [NUM_CH-1:0]       clk_out_a,
  output logic [NUM_CH-1:0]       clk_out_b
);
  logic              sync_frozen;
  logic              release_p;
  logic              run_start;
  logic              first_q;
  logic [NUM_CH-1:0] ch_frozen;
  logic [NUM_CH-1:0] ch_wrap;
  logic [NUM_CH-1:0] ch_level;

  clkdiv_sync_ctrl #(.RELEASE_LAT(RELEASE_LAT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_n     (sync_n),
    .sync_frozen(sync_frozen),
    .release_p  (release_p),
    .run_start  (run_start)
  );

  // the release after reset includes every channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         first_q <= 1'b1;
    else if (run_start) first_q <= 1'b0;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_frozen[i] = sync_frozen & (first_q | ~cfg_nosync[i]);

    clkdiv_channel #(.CNT_W(CNT_W), .PH_W(PH_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .frozen   (ch_frozen[i]),
      .cfg_high (cfg_high[i*CNT_W +: CNT_W]),
      .cfg_low  (cfg_low[i*CNT_W +: CNT_W]),
      .cfg_phase(cfg_phase[i*PH_W +: PH_W]),
      .cfg_start(cfg_start_high[i]),
      .level    (ch_level[i]),
      .wrap     (ch_wrap[i])
    );

    assign clk_out_a[i] = ch_level[i];
    assign clk_out_b[i] = ch_level[i];
  end

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int NUM_CH      = 4,
  parameter int RELEASE_LAT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_frozen,
  input logic              release_p,
  input logic              run_start,
  input logic [NUM_CH-1:0] ch_frozen,
  input logic [NUM_CH-1:0] ch_wrap,
  input logic [NUM_CH-1:0] cfg_start_high,
  input logic [NUM_CH-1:0] clk_out_a
);
  localparam int CC_W = $clog2(RELEASE_LAT + 3) + 1;

  logic [CC_W-1:0] since_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 since_rel <= '0;
    else if (release_p)                         since_rel <= CC_W'(1);
    else if (since_rel != '0 && since_rel != '1) since_rel <= since_rel + 1'b1;
  end

  AST_RELEASE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |-> since_rel == CC_W'(RELEASE_LAT + 1)); // R5

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(ch_frozen[i]) |-> clk_out_a[i] == $past(cfg_start_high[i])); // R2

    AST_FREEZE_ONLY_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      ch_frozen[i] |-> sync_frozen); // R7

    AST_WRAP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(ch_wrap[i]) |-> clk_out_a[i] != $past(clk_out_a[i])); // R4

    AST_NO_STRAY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(ch_frozen[i]) && !$past(ch_wrap[i]) |-> $stable(clk_out_a[i])); // R4
  end

endmodule

bind clkdiv_sync_bank clkdiv_bank_chk #(
  .NUM_CH     (NUM_CH),
  .RELEASE_LAT(RELEASE_LAT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sync_frozen   (sync_frozen),
  .release_p     (release_p),
  .run_start     (run_start),
  .ch_frozen     (ch_frozen),
  .ch_wrap       (ch_wrap),
  .cfg_start_high(cfg_start_high),
  .clk_out_a     (clk_out_a)
);

// File: tb/clkdiv_sync_bank_test.sv
module clkdiv_sync_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 4;
  localparam int PW  = 4;
  localparam int LAT = 10;
  localparam int M_RUN = 0, M_HOLD = 1, M_SKIP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic [NCH*CW-1:0] cfg_high, cfg_low;
  logic [NCH*PW-1:0] cfg_phase;
  logic [NCH-1:0]    cfg_start_high, cfg_nosync;
  logic [NCH-1:0]    clk_out_a, clk_out_b;

  int   c_hi[NCH], c_lo[NCH], c_ph[NCH];
  logic c_st[NCH], c_ns[NCH];

  int    m_hi[NCH], m_lo[NCH], m_f[NCH], mode[NCH];
  logic  m_st[NCH];
  string t_pre[NCH], t_post[NCH];

  int g = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      cfg_high[i*CW +: CW]  = CW'(c_hi[i]);
      cfg_low[i*CW +: CW]   = CW'(c_lo[i]);
      cfg_phase[i*PW +: PW] = PW'(c_ph[i]);
      cfg_start_high[i]     = c_st[i];
      cfg_nosync[i]         = c_ns[i];
    end
  end

  clkdiv_sync_bank #(.NUM_CH(NCH), .CNT_W(CW), .PH_W(PW), .RELEASE_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_phase(cfg_phase),
    .cfg_start_high(cfg_start_high), .cfg_nosync(cfg_nosync),
    .clk_out_a(clk_out_a), .clk_out_b(clk_out_b)
  );

  // level after global edge k for a channel released with first change at edge f
  function automatic logic exp_lvl(int k, int f, logic st, int hi, int lo);
    int per, m, l1;
    if (k < f) return st;
    per = hi + lo + 2;
    m   = (k - f) % per;
    l1  = st ? lo + 1 : hi + 1;
    return (m < l1) ? ~st : st;
  endfunction

  task automatic check_bit(string tag, int ch, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s ch%0d edge %0d: got %b expected %b", tag, ch, g, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < NCH; i++) begin
      check_bit("R3", i, clk_out_b[i], clk_out_a[i]);
      if (mode[i] == M_HOLD)
        check_bit("R2", i, clk_out_a[i], m_st[i]);
      else if (mode[i] == M_RUN)
        check_bit((g < m_f[i]) ? t_pre[i] : t_post[i], i, clk_out_a[i],
                  exp_lvl(g, m_f[i], m_st[i], m_hi[i], m_lo[i]));
    end
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      g++;
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic load_cfg(int r);
    for (int i = 0; i < NCH; i++) begin
      c_hi[i] = (r + 7*i) % 16;
      c_lo[i] = (3*r + i + 5) % 16;
      c_ph[i] = (5*r + 3*i) % 16;
      c_st[i] = logic'((r + i) % 2);
      if (r == 1) begin c_hi[i] = 15; c_lo[i] = 15; c_ph[i] = 15; end
      if (r == 2) begin c_hi[i] = 0;  c_lo[i] = 0;  c_ph[i] = 0;  end
      c_ns[i] = ((r % 3) == 0) && (i == (r / 3) % NCH);
    end
  endtask

  // model a channel released with E1 = next edge
  task automatic arm_channel(int i, string pre);
    m_hi[i] = c_hi[i];
    m_lo[i] = c_lo[i];
    m_st[i] = c_st[i];
    m_f[i]  = g + 1 + 3 + LAT + c_ph[i] + (c_st[i] ? c_hi[i] : c_lo[i]);
    mode[i] = M_RUN;
    t_pre[i]  = pre;
    t_post[i] = "R4";
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) mode[i] = M_SKIP;
    load_cfg(5);
    c_ns[NCH-1] = 1'b1;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        check_bit("R1", i, clk_out_a[i], 1'b0);
        check_bit("R1", i, clk_out_b[i], 1'b0);
      end
    end
    rst_n = 1'b1;
    for (int i = 0; i < NCH; i++) arm_channel(i, "R1");
    tick(120);

    for (int r = 0; r < 40; r++) begin
      load_cfg(r);
      for (int i = 0; i < NCH; i++) if (mode[i] == M_RUN) t_post[i] = "R8";
      tick(30);
      sync_n = 1'b0;
      for (int i = 0; i < NCH; i++) begin
        if (c_ns[i]) t_post[i] = "R7";
        else         mode[i] = M_SKIP;
      end
      tick(4);
      for (int i = 0; i < NCH; i++)
        if (!c_ns[i]) begin mode[i] = M_HOLD; m_st[i] = c_st[i]; end
      tick(8);
      sync_n = 1'b1;
      for (int i = 0; i < NCH; i++)
        if (!c_ns[i]) arm_channel(i, (c_ph[i] != 0) ? "R6" : (c_st[i] ? "R9" : "R5"));
      tick(112);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at edge %0d", g);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule